// File: doc/BRIEF.md
# Pair-sweep and update address sequencer

This block steps the address side of one time step of an all-pairs particle interaction. It holds no arithmetic. After a start pulse it first walks every ordered pair of particles. The target index stays fixed while the source index sweeps the whole set. The target then advances. The sequencer issues one pair per clock to a force pipeline, and it marks the final source of each row so that the accumulators downstream can store and clear their sums.

When the pair sweep ends, the next cycle opens the update sweep. Each particle is read once for its velocity and position update. A write-back index follows each read index through a delay line of fixed length, which matches the latency of the update pipeline. The step is finished when the trailing write index has covered the last particle. Done then pulses for one cycle and the block goes back to idle. One start runs one step.

Top module: `nbody_step_seq`

## Requirements
- R1: While rst_ni is low and after release without start, busy_o, done_o, pair_valid_o, row_last_o, upd_rd_valid_o and upd_wr_valid_o are all 0.
- R2: A start_i sampled high while idle gives, in the next cycle, busy_o=1 and pair_valid_o=1 with tgt_idx_o=0 and src_idx_o=0.
- R3: The pair phase issues exactly N_PART*N_PART consecutive beats, one per cycle. src_idx_o counts 0..N_PART-1 while tgt_idx_o holds, then tgt_idx_o increments and src_idx_o restarts at 0.
- R4: row_last_o is 1 exactly on pair beats where src_idx_o equals N_PART-1.
- R5: In the cycle after the pair (N_PART-1, N_PART-1), the update phase issues upd_rd_idx_o = 0..N_PART-1, one per cycle, with upd_rd_valid_o=1. A pair beat and an update beat never share a cycle.
- R6: upd_wr_valid_o is 1 with upd_wr_idx_o equal to the read index issued LAG cycles earlier (default LAG=2, so read 3 pairs with write 1). Exactly N_PART write beats occur per step.
- R7: In the cycle after the write beat with index N_PART-1, done_o is 1 for exactly one cycle with busy_o=0. The block is idle afterwards.
- R8: start_i is ignored whenever the block is not idle, including the done cycle. It neither restarts nor extends the running step.
- R9: busy_o is 1 from the first pair beat through the last write beat, including the LAG drain cycles in which no read is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin one step when idle |
| busy_o | output | 1 | Step in progress |
| done_o | output | 1 | One-cycle end-of-step pulse |
| pair_valid_o | output | 1 | Pair beat present |
| tgt_idx_o | output | IDX_W | Target (outer) particle index |
| src_idx_o | output | IDX_W | Source (inner) particle index |
| row_last_o | output | 1 | Last source of the current target |
| upd_rd_valid_o | output | 1 | Update read beat present |
| upd_rd_idx_o | output | IDX_W | Particle index to read for update |
| upd_wr_valid_o | output | 1 | Write-back beat present |
| upd_wr_idx_o | output | IDX_W | Particle index to write back |

## Verification
Several functions overlap in time. Inside the update phase, a read of one particle and the write-back of an earlier one happen in the same cycle. The bench checks both indices on every such cycle against a reference that counts beats since start. A second overlap is a start request landing on a busy or done cycle. The bench pulses start in the middle of the pair sweep, during read/write overlap and on the done cycle itself, and each time it requires the beat ordering and the count of accepted steps to stay unchanged. A start held high for several cycles at launch must also produce only one step.

// File: rtl/nbody_seq_pkg.sv
package nbody_seq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PAIR = 2'd1,
    ST_UPD  = 2'd2,
    ST_DONE = 2'd3
  } seq_state_e;
endpackage

// File: rtl/nbody_loop_ctr.sv
module nbody_loop_ctr #(
  parameter int unsigned COUNT = 256,
  parameter int unsigned W     = $clog2(COUNT)
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         en_i,
  output logic [W-1:0] cnt_o,
  output logic         last_o
);
  localparam logic [W-1:0] MAX = W'(COUNT - 1);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (en_i)   cnt_q <= (cnt_q == MAX) ? '0 : cnt_q + 1'b1;
  end

  assign cnt_o  = cnt_q;
  assign last_o = (cnt_q == MAX);
endmodule

// File: rtl/nbody_lag_line.sv
module nbody_lag_line #(
  parameter int unsigned W     = 8,
  parameter int unsigned DEPTH = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         vld_i,
  input  logic [W-1:0] dat_i,
  output logic         vld_o,
  output logic [W-1:0] dat_o
);
  logic [DEPTH-1:0]        vld_q;
  logic [DEPTH-1:0][W-1:0] dat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= '0;
      dat_q <= '0;
    end else begin
      vld_q[0] <= vld_i;
      dat_q[0] <= dat_i;
      for (int s = 1; s < DEPTH; s++) begin
        vld_q[s] <= vld_q[s-1];
        dat_q[s] <= dat_q[s-1];
      end
    end
  end

  assign vld_o = vld_q[DEPTH-1];
  assign dat_o = dat_q[DEPTH-1];
endmodule

// File: rtl/nbody_step_seq.sv
module nbody_step_seq #(
  parameter int unsigned N_PART = 256,
  parameter int unsigned LAG    = 2,
  parameter int unsigned IDX_W  = $clog2(N_PART)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  output logic             busy_o,
  output logic             done_o,
  output logic             pair_valid_o,
  output logic [IDX_W-1:0] tgt_idx_o,
  output logic [IDX_W-1:0] src_idx_o,
  output logic             row_last_o,
  output logic             upd_rd_valid_o,
  output logic [IDX_W-1:0] upd_rd_idx_o,
  output logic             upd_wr_valid_o,
  output logic [IDX_W-1:0] upd_wr_idx_o
);
  import nbody_seq_pkg::*;

  localparam logic [IDX_W-1:0] IDX_MAX = IDX_W'(N_PART - 1);

  seq_state_e       state_q, state_d;
  logic             start_ok;
  logic             in_pair, in_upd;
  logic             src_last, tgt_last, rd_last;
  logic             rd_done_q, rd_vld;
  logic             wr_vld;
  logic [IDX_W-1:0] src_idx, tgt_idx, rd_idx, wr_idx;

  assign start_ok = (state_q == ST_IDLE) && start_i;
  assign in_pair  = (state_q == ST_PAIR);
  assign in_upd   = (state_q == ST_UPD);
  assign rd_vld   = in_upd && !rd_done_q;

  nbody_loop_ctr #(.COUNT(N_PART), .W(IDX_W)) u_src_ctr (
    .clk_i, .rst_ni, .clr_i(start_ok), .en_i(in_pair),
    .cnt_o(src_idx), .last_o(src_last)
  );

  nbody_loop_ctr #(.COUNT(N_PART), .W(IDX_W)) u_tgt_ctr (
    .clk_i, .rst_ni, .clr_i(start_ok), .en_i(in_pair && src_last),
    .cnt_o(tgt_idx), .last_o(tgt_last)
  );

  nbody_loop_ctr #(.COUNT(N_PART), .W(IDX_W)) u_rd_ctr (
    .clk_i, .rst_ni, .clr_i(start_ok), .en_i(rd_vld),
    .cnt_o(rd_idx), .last_o(rd_last)
  );

  // write-back index trails the read index by the update pipeline latency
  nbody_lag_line #(.W(IDX_W), .DEPTH(LAG)) u_lag (
    .clk_i, .rst_ni, .vld_i(rd_vld), .dat_i(rd_idx),
    .vld_o(wr_vld), .dat_o(wr_idx)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (start_i)                    state_d = ST_PAIR;
      ST_PAIR: if (src_last && tgt_last)       state_d = ST_UPD;
      ST_UPD:  if (wr_vld && wr_idx == IDX_MAX) state_d = ST_DONE;
      ST_DONE:                                  state_d = ST_IDLE;
      default:                                  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      rd_done_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (start_ok)                rd_done_q <= 1'b0;
      else if (rd_vld && rd_last)  rd_done_q <= 1'b1;
    end
  end

  assign busy_o         = in_pair || in_upd;
  assign done_o         = (state_q == ST_DONE);
  assign pair_valid_o   = in_pair;
  assign tgt_idx_o      = tgt_idx;
  assign src_idx_o      = src_idx;
  assign row_last_o     = in_pair && src_last;
  assign upd_rd_valid_o = rd_vld;
  assign upd_rd_idx_o   = rd_idx;
  assign upd_wr_valid_o = wr_vld;
  assign upd_wr_idx_o   = wr_idx;
endmodule

// File: rtl/nbody_step_seq_chk.sv
module nbody_step_seq_chk #(
  parameter int unsigned N_PART = 256,
  parameter int unsigned IDX_W  = $clog2(N_PART)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic             busy_o,
  input logic             done_o,
  input logic             pair_valid_o,
  input logic [IDX_W-1:0] tgt_idx_o,
  input logic [IDX_W-1:0] src_idx_o,
  input logic             row_last_o,
  input logic             upd_rd_valid_o,
  input logic [IDX_W-1:0] upd_rd_idx_o,
  input logic             upd_wr_valid_o,
  input logic [IDX_W-1:0] upd_wr_idx_o
);
  localparam logic [IDX_W-1:0] IDX_MAX = IDX_W'(N_PART - 1);

  AST_LAUNCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !done_o && start_i) |=> (pair_valid_o && tgt_idx_o == '0 && src_idx_o == '0)); // R2

  AST_SRC_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pair_valid_o && !row_last_o) |=>
      (pair_valid_o && src_idx_o == IDX_W'($past(src_idx_o) + 1'b1) && $stable(tgt_idx_o))); // R3

  AST_TGT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pair_valid_o && row_last_o && tgt_idx_o != IDX_MAX) |=>
      (pair_valid_o && src_idx_o == '0 && tgt_idx_o == IDX_W'($past(tgt_idx_o) + 1'b1))); // R3

  AST_ROW_LAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pair_valid_o |-> (row_last_o == (src_idx_o == IDX_MAX))); // R4

  AST_PAIR_TO_UPD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pair_valid_o && row_last_o && tgt_idx_o == IDX_MAX) |=>
      (!pair_valid_o && upd_rd_valid_o && upd_rd_idx_o == '0)); // R5

  AST_NO_PHASE_MIX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(pair_valid_o && (upd_rd_valid_o || upd_wr_valid_o))); // R5

  AST_DONE_AFTER_LAST_WR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_wr_valid_o && upd_wr_idx_o == IDX_MAX) |=> (done_o && !busy_o)); // R7

  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> (!done_o && !busy_o)); // R7

  AST_BUSY_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !(upd_wr_valid_o && upd_wr_idx_o == IDX_MAX)) |=> busy_o); // R9
endmodule

bind nbody_step_seq nbody_step_seq_chk #(.N_PART(N_PART), .IDX_W(IDX_W)) u_chk (.*);

// File: tb/tb_nbody_step_seq.sv
`timescale 1ns/1ps
module tb_nbody_step_seq;
  localparam int N    = 256;
  localparam int LAG  = 2;
  localparam int W    = $clog2(N);
  localparam int NN   = N * N;
  localparam int ENDK = NN + N + LAG;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic busy, done, pv, rl, rv, wv;
  logic [W-1:0] tgt, src, rdi, wri;

  always #2 clk = ~clk;

  nbody_step_seq #(.N_PART(N), .LAG(LAG)) dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start),
    .busy_o(busy), .done_o(done), .pair_valid_o(pv),
    .tgt_idx_o(tgt), .src_idx_o(src), .row_last_o(rl),
    .upd_rd_valid_o(rv), .upd_rd_idx_o(rdi),
    .upd_wr_valid_o(wv), .upd_wr_idx_o(wri)
  );

  int n_chk = 0, n_bad = 0;

  task automatic chk(input string tag, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s got=%0d exp=%0d at %0t", tag, got, exp, $time);
    end
  endtask

  // reference: beat number since accepted start
  int m_act = 0, m_k = 0;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_act <= 0; m_k <= 0;
    end else if (m_act == 0) begin
      if (start) begin m_act <= 1; m_k <= 0; end
    end else if (m_k == ENDK) m_act <= 0;
    else m_k <= m_k + 1;
  end

  int pc = 0, rc = 0, wc = 0, runs = 0;
  logic busy_prev = 1'b0;

  always @(negedge clk) begin
    bit e_pair, e_rd, e_wr, e_busy, e_done;
    int j;
    string t;
    j      = m_k - NN;
    e_pair = m_act != 0 && m_k < NN;
    e_rd   = m_act != 0 && m_k >= NN && j < N;
    e_wr   = m_act != 0 && m_k >= NN && j >= LAG && j < N + LAG;
    e_busy = m_act != 0 && m_k < ENDK;
    e_done = m_act != 0 && m_k == ENDK;
    t = rst_n ? "R3" : "R1";
    chk(t, int'(pv), int'(e_pair));
    if (e_pair && pv) begin
      chk("R3", int'(tgt), m_k / N);
      chk("R3", int'(src), m_k % N);
      if (m_k == 0) chk("R2", int'(tgt == '0 && src == '0 && busy), 1);
    end
    chk(rst_n ? "R4" : "R1", int'(rl), int'(e_pair && (m_k % N) == N - 1));
    chk(rst_n ? "R5" : "R1", int'(rv), int'(e_rd));
    if (e_rd && rv) chk("R5", int'(rdi), j);
    chk(rst_n ? "R6" : "R1", int'(wv), int'(e_wr));
    if (e_wr && wv) chk("R6", int'(wri), j - LAG);
    chk(rst_n ? "R9" : "R1", int'(busy), int'(e_busy));
    chk(rst_n ? "R7" : "R1", int'(done), int'(e_done));
    if (rst_n) begin
      if (pv) pc++;
      if (rv) rc++;
      if (wv) wc++;
      if (busy && !busy_prev) runs++;
      busy_prev = busy;
      if (done) begin
        chk("R3", pc, NN);
        chk("R5", rc, N);
        chk("R6", wc, N);
        pc = 0; rc = 0; wc = 0;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    start = 1'b1;                       // R2 launch
    @(negedge clk); start = 1'b0;
    repeat (1000) @(negedge clk);
    start = 1'b1;                       // R8 mid pair sweep
    @(negedge clk); start = 1'b0;
    while (!wv) @(negedge clk);
    start = 1'b1;                       // R8 during read/write overlap
    @(negedge clk); start = 1'b0;
    while (!done) @(negedge clk);
    start = 1'b1;                       // R8 on the done cycle
    @(negedge clk); start = 1'b0;
    repeat (3) @(negedge clk);
    chk("R8", int'(busy), 0);
    chk("R8", runs, 1);
    start = 1'b1;                       // held high: one step only
    repeat (3) @(negedge clk);
    start = 1'b0;
    while (!done) @(negedge clk);
    repeat (4) @(negedge clk);
    chk("R8", runs, 2);
    chk("R1", int'(busy || done || pv || rv || wv), 0);
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule